// File: doc/BRIEF.md
# Predicated Vector Load Address Sequencer

This block turns one vectorised load with an immediate offset into a series of per-element memory requests. A start pulse captures the vector length, a source and a destination predicate mask, flags that mark the base, destination and update operands as scalar or vector, an operation size, a signed immediate, a shift amount and one of four addressing modes. The block then presents one request per cycle on a valid/ready port. Each request carries an effective address, the destination element index, and optionally the base-update element index. The value written back on an update is the request address itself.

The base operand is read through a combinational read port. The block drives an element index and receives that element's value in the same cycle. The caller keeps the register contents steady while an operation runs. Three element counters are kept: source, destination and update. Each one hops over elements whose predicate bit is clear. The operation ends when an active counter runs out of elements, or after one request when the destination is scalar.

Top module: `vload_addr_seq`

## Requirements
- R1: After reset no request is valid and done is low. The start input is sampled only while idle; a start during an operation has no effect on the running request stream.
- R2: Mode 0 (plain): the address is base element i plus the sign-extended immediate when the base is a vector. When the base is scalar, the address is scalar base plus immediate for every element (splat).
- R3: Mode 1 (unit stride): the address is scalar base + immediate + (i << size). Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes.
- R4: Mode 2 (element stride): the address is scalar base + i × immediate.
- R5: Mode 3 (shifted): the address is base + ((i × immediate) << shift). The base is element i when the base is a vector, otherwise the scalar base.
- R6: The destination index skips clear bits of the destination mask when the destination is a vector. The source index skips clear bits of the source mask when the base is a vector or the mode is 1, 2 or 3. The update index skips clear bits of the source mask when the update operand is a vector. A scalar operand's index stays 0.
- R7: When update is enabled, every request flags an update, and the update index is the update counter (0 if the update operand is scalar).
- R8: A scalar destination ends the operation after its first accepted request.
- R9: The operation ends without a further request when any active index reaches the vector length, including by skipping. A length of 0 issues nothing. A length above the maximum is treated as the maximum.
- R10: A request with ready low holds its address and indices until it is accepted. Done is high for exactly one cycle: the cycle after the last acceptance, or the cycle after start if nothing is issued. Done is never high together with a valid request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| vl | input | IW | Vector length |
| src_mask | input | MAX_VL | Source predicate |
| dst_mask | input | MAX_VL | Destination predicate |
| base_vec | input | 1 | Base operand is a vector |
| dst_vec | input | 1 | Destination is a vector |
| upd_en | input | 1 | Write effective address back to update operand |
| upd_vec | input | 1 | Update operand is a vector |
| mode | input | 2 | 0 plain, 1 unit, 2 element, 3 shifted |
| op_size | input | 2 | log2 of operation bytes |
| imm | input | IMM_W | Signed immediate |
| shamt | input | SH_W | Shift for mode 3 |
| rd_idx | output | IW | Base element index to read |
| rd_data | input | AW | Base element value |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted |
| req_addr | output | AW | Effective address |
| req_dst | output | IW | Destination element index |
| req_upd | output | 1 | Update write requested |
| req_upd_idx | output | IW | Update element index |
| done | output | 1 | Operation finished |

## Verification
The address formulas are tried with a scalar base and full masks, which separates the splat form from the strided forms. They are also tried with a vector base and a sparse source mask, which shows whether the base element and the multiplier follow the skipped source index. A sparse destination mask used with a dense source mask shows that the two counters advance independently. A negative immediate and each operation size catch sign-extension and scaling errors. Stalled ready patterns, a mid-operation start, a zero length, an over-long length and a mask whose only remaining bit lies beyond the length cover the handshake and end conditions.

// File: rtl/vload_addr_seq.sv
module vload_addr_seq #(
  parameter int MAX_VL = 8,
  parameter int AW     = 64,
  parameter int IMM_W  = 16,
  parameter int SH_W   = 6,
  parameter int IW     = $clog2(MAX_VL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     vl,
  input  logic [MAX_VL-1:0] src_mask,
  input  logic [MAX_VL-1:0] dst_mask,
  input  logic              base_vec,
  input  logic              dst_vec,
  input  logic              upd_en,
  input  logic              upd_vec,
  input  logic [1:0]        mode,
  input  logic [1:0]        op_size,
  input  logic [IMM_W-1:0]  imm,
  input  logic [SH_W-1:0]   shamt,
  output logic [IW-1:0]     rd_idx,
  input  logic [AW-1:0]     rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [AW-1:0]     req_addr,
  output logic [IW-1:0]     req_dst,
  output logic              req_upd,
  output logic [IW-1:0]     req_upd_idx,
  output logic              done
);
  localparam logic [1:0] M_PLAIN = 2'd0;
  localparam logic [1:0] M_UNIT  = 2'd1;
  localparam logic [1:0] M_ELEM  = 2'd2;
  localparam logic [1:0] M_SHIFT = 2'd3;
  localparam logic [IW-1:0] VL_CAP = IW'(MAX_VL);

  logic              busy, stop;
  logic [IW-1:0]     vl_q, i_q, j_q, u_q;
  logic [MAX_VL-1:0] sm_q, dm_q;
  logic              bv_q, dv_q, ue_q, uv_q;
  logic [1:0]        mode_q, sz_q;
  logic [IMM_W-1:0]  imm_q;
  logic [SH_W-1:0]   sh_q;

  function automatic logic [IW-1:0] next_set(input logic [MAX_VL-1:0] m,
                                             input logic [IW-1:0] from);
    logic [IW-1:0] r;
    r = VL_CAP;
    for (int k = MAX_VL - 1; k >= 0; k--)
      if (m[k] && (IW'(k) >= from)) r = IW'(k);
    return r;
  endfunction

  logic          iv, term;
  logic [IW-1:0] ei, ej, eu;
  logic [AW-1:0] imm_x, ei_x, prod, offs;

  assign iv = bv_q | (mode_q != M_PLAIN);
  assign ei = iv   ? next_set(sm_q, i_q) : i_q;
  assign ej = dv_q ? next_set(dm_q, j_q) : j_q;
  assign eu = uv_q ? next_set(sm_q, u_q) : u_q;

  assign term = stop | (vl_q == '0) | (iv && ei >= vl_q) | (dv_q && ej >= vl_q)
              | (ue_q && uv_q && eu >= vl_q);

  assign req_valid   = busy & ~term;
  assign done        = busy & term;
  assign req_dst     = dv_q ? ej : '0;
  assign req_upd     = ue_q;
  assign req_upd_idx = uv_q ? eu : '0;
  assign rd_idx      = (bv_q && (mode_q == M_PLAIN || mode_q == M_SHIFT)) ? ei : '0;

  assign imm_x = {{(AW-IMM_W){imm_q[IMM_W-1]}}, imm_q};
  assign ei_x  = {{(AW-IW){1'b0}}, ei};
  assign prod  = ei_x * imm_x;

  always_comb begin
    case (mode_q)
      M_UNIT:  offs = imm_x + (ei_x << sz_q);
      M_ELEM:  offs = prod;
      M_SHIFT: offs = prod << sh_q;
      default: offs = imm_x;
    endcase
  end

  assign req_addr = rd_data + offs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; stop <= 1'b0;
      vl_q <= '0; i_q <= '0; j_q <= '0; u_q <= '0;
      sm_q <= '0; dm_q <= '0;
      bv_q <= 1'b0; dv_q <= 1'b0; ue_q <= 1'b0; uv_q <= 1'b0;
      mode_q <= M_PLAIN; sz_q <= '0; imm_q <= '0; sh_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        stop   <= 1'b0;
        vl_q   <= (vl > VL_CAP) ? VL_CAP : vl;
        i_q    <= '0; j_q <= '0; u_q <= '0;
        sm_q   <= src_mask; dm_q <= dst_mask;
        bv_q   <= base_vec; dv_q <= dst_vec;
        ue_q   <= upd_en;   uv_q <= upd_vec;
        mode_q <= mode;     sz_q <= op_size;
        imm_q  <= imm;      sh_q <= shamt;
      end
    end else if (term) begin
      busy <= 1'b0;
    end else if (req_ready) begin
      if (!dv_q) stop <= 1'b1;
      if (iv)    i_q  <= ei + IW'(1);
      j_q <= ej + IW'(1);
      if (uv_q)  u_q  <= eu + IW'(1);
    end
  end
endmodule

module vload_addr_seq_chk #(
  parameter int MAX_VL = 8,
  parameter int AW     = 64,
  parameter int IW     = $clog2(MAX_VL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [AW-1:0]     req_addr,
  input logic [IW-1:0]     req_dst,
  input logic              req_upd,
  input logic [IW-1:0]     req_upd_idx,
  input logic              done,
  input logic              dv,
  input logic              uv,
  input logic [MAX_VL-1:0] sm,
  input logic [MAX_VL-1:0] dm
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_dst)
                                && $stable(req_upd_idx));

  a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !done);

  a_r6_dst_pred: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && dv |-> |(dm & (MAX_VL'(1) << req_dst)));

  a_r6_upd_pred: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_upd && uv |-> |(sm & (MAX_VL'(1) << req_upd_idx)));

  a_r6_dst_rising: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && dv |=> !req_valid || (req_dst > $past(req_dst)));

  a_r8_scalar_end: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !dv |=> done);
endmodule

bind vload_addr_seq vload_addr_seq_chk #(.MAX_VL(MAX_VL), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_dst(req_dst), .req_upd(req_upd),
  .req_upd_idx(req_upd_idx), .done(done), .dv(dv_q), .uv(uv_q),
  .sm(sm_q), .dm(dm_q));

// File: tb/sim_vload_addr_seq.sv
module sim_vload_addr_seq;
  localparam int CLK_P = 10;
  localparam int MAXV  = 8;
  localparam int IW    = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic [IW-1:0] vl = 0;
  logic [7:0] src_mask = 0, dst_mask = 0;
  logic base_vec = 0, dst_vec = 0, upd_en = 0, upd_vec = 0;
  logic [1:0] mode = 0, op_size = 0;
  logic [15:0] imm = 0;
  logic [5:0] shamt = 0;
  logic [IW-1:0] rd_idx;
  logic [63:0] rd_data;
  logic req_valid, req_ready = 0, req_upd, done;
  logic [63:0] req_addr;
  logic [IW-1:0] req_dst, req_upd_idx;
  logic [63:0] rf [8];

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  assign rd_data = rf[rd_idx[2:0]];

  vload_addr_seq u0 (.*);

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int nxt(input logic [7:0] m, input int from);
    for (int k = from; k < MAXV; k++) if (m[k]) return k;
    return MAXV;
  endfunction

  task automatic run(input string tag, input int vl_i, input logic [7:0] sm, input logic [7:0] dm,
                     input bit bv, input bit dv, input bit ue, input bit uv,
                     input logic [1:0] md, input logic [1:0] sz, input logic [15:0] im,
                     input logic [5:0] sh, input bit stall, input bit poke);
    logic [63:0] ea [16];
    int ed [16], eu [16];
    int n_exp = 0, n = 0, i = 0, j = 0, u = 0, vlc;
    bit ivec, held = 0, last_evt = 1, fin = 0;
    logic [63:0] h_addr, base, off, immx;
    int h_dst;
    vlc  = (vl_i > MAXV) ? MAXV : vl_i;
    ivec = bv || (md != 2'd0);
    immx = {{48{im[15]}}, im};
    while (vlc != 0 && n_exp < 16) begin
      int ci, cj, cu;
      ci = ivec ? nxt(sm, i) : i;
      cj = dv ? nxt(dm, j) : j;
      cu = uv ? nxt(sm, u) : u;
      if ((ivec && ci >= vlc) || (dv && cj >= vlc) || (ue && uv && cu >= vlc)) break;
      base = (bv && (md == 2'd0 || md == 2'd3)) ? rf[ci] : rf[0];
      case (md)
        2'd1: off = immx + (64'(ci) << sz);
        2'd2: off = 64'(ci) * immx;
        2'd3: off = (64'(ci) * immx) << sh;
        default: off = immx;
      endcase
      ea[n_exp] = base + off; ed[n_exp] = dv ? cj : 0; eu[n_exp] = uv ? cu : 0;
      n_exp++;
      if (!dv) break;
      if (ivec) i = ci + 1;
      j = cj + 1;
      if (uv) u = cu + 1;
    end

    @(negedge clk);
    vl = IW'(vl_i); src_mask = sm; dst_mask = dm; base_vec = bv; dst_vec = dv;
    upd_en = ue; upd_vec = uv; mode = md; op_size = sz; imm = im; shamt = sh;
    start = 1; req_ready = 0;
    @(negedge clk);
    start = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      req_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (poke) begin
        start = (cyc == 1);
        if (cyc == 1) begin vl = 0; mode = 2'd0; imm = 16'h7; end
      end
      #1;
      if (held) begin
        chk("R10", "held valid", req_valid, 1);
        chk("R10", "held addr", req_addr, h_addr);
        chk("R10", "held dst", req_dst, h_dst);
        held = 0;
      end
      if (done) begin
        chk("R10", "done timing", last_evt, 1);
        chk(tag, "request count", n, n_exp);
        chk("R10", "done with valid", req_valid, 0);
        fin = 1;
        break;
      end
      if (req_valid) begin
        if (n < n_exp) begin
          if (req_ready) begin
            chk(tag, "addr", req_addr, ea[n]);
            chk("R6", "dst idx", req_dst, ed[n]);
            chk("R7", "upd flag", req_upd, ue);
            if (ue) chk("R7", "upd idx", req_upd_idx, eu[n]);
          end else begin
            held = 1; h_addr = req_addr; h_dst = req_dst;
          end
        end else begin
          chk(tag, "extra request", 1, 0);
        end
      end
      last_evt = req_valid && req_ready;
      if (req_valid && req_ready) n++;
      @(negedge clk);
    end
    start = 0;
    if (!fin) chk("R10", "done seen", 0, 1);
    req_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) rf[k] = 64'h0000_1000_0000_0000 + 64'(k) * 64'h1_0100;
    repeat (3) @(negedge clk);
    chk("R1", "valid in reset", req_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "valid after reset", req_valid, 0);
    chk("R1", "done after reset", done, 0);
    // R2 splat and indexed, R6 source skipping
    run("R2", 4, 8'hff, 8'hff, 0, 1, 0, 0, 2'd0, 2'd0, 16'd16, 6'd0, 0, 0);
    run("R2", 8, 8'b1011_0110, 8'hff, 1, 1, 0, 0, 2'd0, 2'd0, 16'hfffc, 6'd0, 0, 0);
    // R3 unit stride with stalls and a start while busy (R1, R10)
    run("R3", 5, 8'hff, 8'hff, 0, 1, 0, 0, 2'd1, 2'd3, 16'hfff8, 6'd0, 1, 1);
    run("R3", 3, 8'hff, 8'hff, 0, 1, 0, 0, 2'd1, 2'd1, 16'd2, 6'd0, 0, 0);
    // R4 element stride, sparse destination mask (R6)
    run("R4", 8, 8'hff, 8'b0101_1010, 0, 1, 0, 0, 2'd2, 2'd0, 16'd24, 6'd0, 0, 0);
    // R5 shifted, vector base, vector update (R7), stalls
    run("R5", 6, 8'b1110_1101, 8'hff, 1, 1, 1, 1, 2'd3, 2'd0, 16'd3, 6'd2, 1, 0);
    // R7 scalar update operand
    run("R7", 3, 8'hff, 8'hff, 0, 1, 1, 0, 2'd0, 2'd0, 16'd8, 6'd0, 0, 0);
    // R8 scalar destination picks first set source element
    run("R8", 8, 8'b0001_0000, 8'h00, 1, 0, 0, 0, 2'd0, 2'd0, 16'd0, 6'd0, 0, 0);
    // R9 skip beyond length, zero length, clamped length
    run("R9", 4, 8'hff, 8'b1000_0001, 0, 1, 0, 0, 2'd0, 2'd0, 16'd0, 6'd0, 0, 0);
    run("R9", 0, 8'hff, 8'hff, 0, 1, 0, 0, 2'd1, 2'd0, 16'd0, 6'd0, 0, 0);
    run("R9", 12, 8'hff, 8'hff, 0, 1, 0, 0, 2'd1, 2'd0, 16'd0, 6'd0, 0, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule